// File: doc/BRIEF.md
# Inter-Processor Doorbell Interrupt Block

This block is the receive-and-send doorbell for one processing agent among eleven agents that signal each other with interrupts. Other agents raise its inbound request lines. Each raised request latches into a sticky pending bit. A mask decides which pending bits reach the single level interrupt output. The owning agent uses a small register port to send doorbells to the other agents, as one-cycle pulses on eleven outbound trigger lines. It also uses the port to acknowledge pending bits and to enable or disable sources.

Each source has a fixed bit in the 32-bit register word: bits 0, 8, 9, 16, 17, 18, 19, 24, 25, 26 and 27 (mask 0x0F0F0301). Source slot k on the 11-bit outbound buses is the k-th of these positions in ascending order. Slot 0 is bit 0 and slot 10 is bit 27. The eleven outbound observe lines mirror the pending bits, so a requester can tell that its doorbell is still unacknowledged. A read of the observe register shows the levels of the 32 inbound observe lines at the source positions.

Word offsets: trigger 0x00, observe 0x04, pending 0x10, mask 0x14, enable 0x18, disable 0x1C. An access with address bits [1:0] not zero is treated as unmapped. Reads are combinational from the address. Writes take effect at the clock edge where the write strobe is high.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset the pending register reads 0, the mask register reads 0x0F0F0301, and irqOut, trigOut and obsOut are all 0.
- R2: Bits outside 0x0F0F0301 read as 0 in every register. Requests and writes on those bits change nothing.
- R3: A write to offset 0x00 drives trigOut[k] high with write bit POS(k) for exactly the cycle after the write edge, then trigOut returns to 0. Offset 0x00 always reads 0.
- R4: A high inbound request at a source position, sampled at a clock edge, sets that pending bit. The bit stays set after the request falls.
- R5: Writing 1 to a pending bit at offset 0x10 clears it. Writing 0 leaves it unchanged.
- R6: Writing 1s to offset 0x18 clears those mask bits, and writing 1s to offset 0x1C sets them. Both offsets read 0. A direct write to offset 0x14 has no effect.
- R7: irqOut is high exactly when some pending bit has a clear mask bit. It follows each change on the cycle after the edge that caused it.
- R8: Offset 0x04 reads the inbound observe levels sampled at the last clock edge, limited to the source positions.
- R9: obsOut[k] equals pending bit POS(k).
- R10: If a request and a clearing write hit the same pending bit at the same edge, the bit stays set.
- R11: Reads of unmapped offsets (0x08, 0x0C, 0x20 and above, or any misaligned address) return 0. Writes to them change no state and produce no trigger pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| reqIn | input | 32 | Inbound request levels, one per bit position |
| obsIn | input | 32 | Inbound observe levels, one per bit position |
| trigOut | output | 11 | Outbound doorbell pulses, one per source slot |
| obsOut | output | 11 | Outbound mirror of pending bits, one per source slot |
| irqOut | output | 1 | Level interrupt to the owning agent |

## Verification
A corrupted pending bit shows on obsOut the cycle after the faulty edge and, when that source is unmasked, on irqOut as well. A wrong mask bit only shows on irqOut while the source is pending, so the bench first sets every pending bit and then walks enable and disable across each source one at a time. A wrong slot-to-bit mapping shows as a trigger pulse or mirror bit in the wrong slot. This is caught by sweeping single bits through every source position on the trigger, request, clear and observe paths.

// File: rtl/ipi_mailbox_pkg.sv
package ipi_mailbox_pkg;

  // Word offsets (byte address >> 2)
  localparam int OFS_TRIG = 0;
  localparam int OFS_OBS  = 1;
  localparam int OFS_STAT = 4;
  localparam int OFS_MASK = 5;
  localparam int OFS_EN   = 6;
  localparam int OFS_DIS  = 7;

  typedef struct packed {
    logic trig;
    logic stClr;
    logic mEn;
    logic mDis;
  } wrStrobe_t;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_OBS  = 2'd1,
    RD_STAT = 2'd2,
    RD_MASK = 2'd3
  } rdSel_t;

  function automatic int countSrc(input logic [31:0] m);
    int n;
    n = 0;
    for (int b = 0; b < 32; b++) if (m[b]) n++;
    return n;
  endfunction

endpackage

// File: rtl/ipi_mailbox_ctrl.sv
module ipi_mailbox_ctrl
  import ipi_mailbox_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output wrStrobe_t         strobes,
  output rdSel_t            rdSel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);

  always_comb begin
    strobes = '0;
    rdSel   = RD_ZERO;
    if (aligned) begin
      case (wordIdx)
        WORD_W'(OFS_TRIG): strobes.trig  = regWrEn;
        WORD_W'(OFS_OBS):  rdSel         = RD_OBS;
        WORD_W'(OFS_STAT): begin
          strobes.stClr = regWrEn;
          rdSel         = RD_STAT;
        end
        WORD_W'(OFS_MASK): rdSel         = RD_MASK;
        WORD_W'(OFS_EN):   strobes.mEn   = regWrEn;
        WORD_W'(OFS_DIS):  strobes.mDis  = regWrEn;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ipi_mailbox_dp.sv
module ipi_mailbox_dp
  import ipi_mailbox_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] SRC_MASK = 32'h0F0F0301,
  parameter int          NUM_SRC  = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobe_t          strobes,
  input  rdSel_t             rdSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  reqIn,
  input  logic [DATA_W-1:0]  obsIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] trigOut,
  output logic [NUM_SRC-1:0] obsOut,
  output logic               irqOut
);
  localparam logic [DATA_W-1:0] VMASK = DATA_W'(SRC_MASK);

  logic [DATA_W-1:0]  status;
  logic [DATA_W-1:0]  maskReg;
  logic [DATA_W-1:0]  obsSamp;
  logic [DATA_W-1:0]  wrValid;
  logic [DATA_W-1:0]  reqValid;
  logic [DATA_W-1:0]  statusNext;
  logic [DATA_W-1:0]  maskNext;
  logic [NUM_SRC-1:0] trigNext;

  function automatic logic [NUM_SRC-1:0] packSrc(input logic [DATA_W-1:0] v);
    logic [NUM_SRC-1:0] r;
    int slot;
    r    = '0;
    slot = 0;
    for (int b = 0; b < DATA_W; b++) begin
      if (VMASK[b]) begin
        if (slot < NUM_SRC) r[slot] = v[b];
        slot++;
      end
    end
    return r;
  endfunction

  assign wrValid  = wrData & VMASK;
  assign reqValid = reqIn & VMASK;

  // Clear first, then set: a same-edge request overrides the acknowledge.
  always_comb begin
    statusNext = status;
    if (strobes.stClr) statusNext = statusNext & ~wrValid;
    statusNext = statusNext | reqValid;
  end

  always_comb begin
    maskNext = maskReg;
    if (strobes.mEn)  maskNext = maskNext & ~wrValid;
    if (strobes.mDis) maskNext = maskNext | wrValid;
  end

  assign trigNext = strobes.trig ? packSrc(wrValid) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status  <= '0;
      maskReg <= VMASK;
      obsSamp <= '0;
      trigOut <= '0;
    end else begin
      status  <= statusNext;
      maskReg <= maskNext;
      obsSamp <= obsIn & VMASK;
      trigOut <= trigNext;
    end
  end

  assign obsOut = packSrc(status);
  assign irqOut = |(status & ~maskReg);

  always_comb begin
    case (rdSel)
      RD_OBS:  rdData = obsSamp;
      RD_STAT: rdData = status;
      RD_MASK: rdData = maskReg;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_mailbox_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] SRC_MASK = 32'h0F0F0301,
  parameter int          NUM_SRC  = countSrc(SRC_MASK)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [DATA_W-1:0]  reqIn,
  input  logic [DATA_W-1:0]  obsIn,
  output logic [NUM_SRC-1:0] trigOut,
  output logic [NUM_SRC-1:0] obsOut,
  output logic               irqOut
);
  wrStrobe_t strobes;
  rdSel_t    rdSel;

  ipi_mailbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  ipi_mailbox_dp #(
    .DATA_W   (DATA_W),
    .SRC_MASK (SRC_MASK),
    .NUM_SRC  (NUM_SRC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdSel   (rdSel),
    .wrData  (regWrData),
    .reqIn   (reqIn),
    .obsIn   (obsIn),
    .rdData  (regRdData),
    .trigOut (trigOut),
    .obsOut  (obsOut),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] SRC_MASK = 32'h0F0F0301,
  parameter int          NUM_SRC  = 11
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [DATA_W-1:0]  regRdData,
  input logic [DATA_W-1:0]  reqIn,
  input logic [NUM_SRC-1:0] trigOut,
  input logic [NUM_SRC-1:0] obsOut,
  input logic               irqOut
);
  localparam logic [DATA_W-1:0] VMASK = DATA_W'(SRC_MASK);

  logic trigWr, statWr, enWr;
  logic [NUM_SRC-1:0] reqC;

  assign trigWr = regWrEn && (regAddr == ADDR_W'(8'h00));
  assign statWr = regWrEn && (regAddr == ADDR_W'(8'h10));
  assign enWr   = regWrEn && (regAddr == ADDR_W'(8'h18));

  always_comb begin
    int slot;
    reqC = '0;
    slot = 0;
    for (int b = 0; b < DATA_W; b++) begin
      if (VMASK[b]) begin
        if (slot < NUM_SRC) reqC[slot] = reqIn[b];
        slot++;
      end
    end
  end

  AST_TRIG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|trigOut) |-> $past(trigWr)); // R3
  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ((|trigOut) && !trigWr) |=> (trigOut == '0)); // R3
  AST_REQ_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (reqC != '0) |=> ((obsOut & $past(reqC)) == $past(reqC))); // R10
  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(obsOut) & ~obsOut)) |-> $past(statWr)); // R5
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past((reqC != '0) || enWr)); // R7
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (obsOut != '0)); // R9
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((regRdData & ~VMASK) == '0)); // R2
endmodule

bind ipi_mailbox ipi_mailbox_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .SRC_MASK (SRC_MASK),
  .NUM_SRC  (NUM_SRC)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regRdData (regRdData),
  .reqIn     (reqIn),
  .trigOut   (trigOut),
  .obsOut    (obsOut),
  .irqOut    (irqOut)
);

// File: tb/ipi_mailbox_tb.sv
module ipi_mailbox_tb;
  localparam logic [31:0] VM   = 32'h0F0F0301;
  localparam logic [31:0] RSVD = 32'hF0F0FCFE;
  localparam int          NS   = 11;
  localparam int POS [NS] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};
  localparam logic [5:0] A_TRIG = 6'h00, A_OBS = 6'h04, A_STAT = 6'h10,
                         A_MASK = 6'h14, A_EN = 6'h18, A_DIS = 6'h1C;

  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [31:0] reqIn;
  logic [31:0] obsIn;
  logic [NS-1:0] trigOut;
  logic [NS-1:0] obsOut;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] expStat;
  logic [31:0] expMask;

  always #4 clk = ~clk;

  ipi_mailbox u_dut (
    .clk (clk), .rstN (rstN), .regAddr (regAddr), .regWrEn (regWrEn),
    .regWrData (regWrData), .regRdData (regRdData), .reqIn (reqIn),
    .obsIn (obsIn), .trigOut (trigOut), .obsOut (obsOut), .irqOut (irqOut)
  );

  function automatic logic [NS-1:0] pk(input logic [31:0] v);
    logic [NS-1:0] r;
    for (int k = 0; k < NS; k++) r[k] = v[POS[k]];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdChk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic pulseReq(input logic [31:0] v);
    reqIn = v;
    @(negedge clk);
    reqIn = '0;
  endtask

  task automatic finish();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish();
    end
  end

  initial begin
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    reqIn = '0; obsIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expStat = '0; expMask = VM;

    // R1 reset state
    rdChk("R1 pending", A_STAT, 32'h0);
    rdChk("R1 mask", A_MASK, 32'h0F0F0301);
    chk("R1 irq", {31'b0, irqOut}, 32'h0);
    chk("R1 trig", {21'b0, trigOut}, 32'h0);
    chk("R1 obsOut", {21'b0, obsOut}, 32'h0);

    // R3 trigger sweep, reserved bits set too
    for (int k = 0; k < NS; k++) begin
      wr(A_TRIG, (32'h1 << POS[k]) | RSVD);
      chk($sformatf("R3 pulse slot %0d", k), {21'b0, trigOut}, 32'h1 << k);
      @(negedge clk);
      chk($sformatf("R3 return slot %0d", k), {21'b0, trigOut}, 32'h0);
    end
    wr(A_TRIG, 32'hFFFF_FFFF);
    chk("R3 all slots", {21'b0, trigOut}, 32'h7FF);
    rdChk("R3 reads zero", A_TRIG, 32'h0);
    @(negedge clk);
    chk("R3 all return", {21'b0, trigOut}, 32'h0);
    rdChk("R3 pending untouched", A_STAT, 32'h0);

    // R2 reserved requests ignored
    pulseReq(RSVD);
    rdChk("R2 reserved req", A_STAT, 32'h0);

    // R4/R9 request sweep; all masked so no irq
    for (int k = 0; k < NS; k++) begin
      pulseReq(32'h1 << POS[k]);
      expStat |= 32'h1 << POS[k];
      @(negedge clk);
      rdChk($sformatf("R4 sticky slot %0d", k), A_STAT, expStat);
      chk($sformatf("R9 mirror slot %0d", k), {21'b0, obsOut}, {21'b0, pk(expStat)});
      chk("R7 masked irq", {31'b0, irqOut}, 32'h0);
    end

    // R6 mask register handling, R7 irq per source
    wr(A_MASK, 32'h0);
    rdChk("R6 mask write ignored", A_MASK, expMask);
    rdChk("R6 enable reads zero", A_EN, 32'h0);
    rdChk("R6 disable reads zero", A_DIS, 32'h0);
    for (int k = 0; k < NS; k++) begin
      wr(A_EN, (32'h1 << POS[k]) | RSVD);
      expMask &= ~(32'h1 << POS[k]);
      rdChk($sformatf("R6 enable slot %0d", k), A_MASK, expMask);
      chk($sformatf("R7 irq on slot %0d", k), {31'b0, irqOut}, 32'h1);
      wr(A_DIS, (32'h1 << POS[k]) | RSVD);
      expMask |= 32'h1 << POS[k];
      rdChk($sformatf("R6 disable slot %0d", k), A_MASK, expMask);
      chk($sformatf("R7 irq off slot %0d", k), {31'b0, irqOut}, 32'h0);
    end
    wr(A_EN, 32'hFFFF_FFFF);
    expMask = '0;
    rdChk("R2 mask all enabled", A_MASK, 32'h0);

    // R5 acknowledge sweep
    for (int k = 0; k < NS; k++) begin
      wr(A_STAT, 32'h0);
      rdChk($sformatf("R5 zero write slot %0d", k), A_STAT, expStat);
      wr(A_STAT, (32'h1 << POS[k]) | RSVD);
      expStat &= ~(32'h1 << POS[k]);
      rdChk($sformatf("R5 clear slot %0d", k), A_STAT, expStat);
      chk($sformatf("R9 mirror clr %0d", k), {21'b0, obsOut}, {21'b0, pk(expStat)});
      chk($sformatf("R7 irq level %0d", k), {31'b0, irqOut}, {31'b0, expStat != 0});
    end

    // R10 request beats same-edge clear
    reqIn = 32'h1 << POS[3];
    wr(A_STAT, 32'h1 << POS[3]);
    reqIn = '0;
    rdChk("R10 request wins", A_STAT, 32'h1 << POS[3]);
    chk("R10 irq", {31'b0, irqOut}, 32'h1);
    wr(A_STAT, 32'h1 << POS[3]);
    rdChk("R10 later clear", A_STAT, 32'h0);

    // R8 observe sampling
    for (int k = 0; k < NS; k++) begin
      obsIn = 32'h1 << POS[k];
      @(negedge clk);
      rdChk($sformatf("R8 observe slot %0d", k), A_OBS, 32'h1 << POS[k]);
    end
    obsIn = 32'hA5A5_A5A5; @(negedge clk);
    rdChk("R8 observe pattern", A_OBS, 32'hA5A5_A5A5 & VM);
    obsIn = 32'hFFFF_FFFF; @(negedge clk);
    rdChk("R8 observe all", A_OBS, VM);
    obsIn = 32'h0; @(negedge clk);
    rdChk("R8 observe none", A_OBS, 32'h0);

    // R11 unmapped offsets
    pulseReq(32'h1 << POS[10] | 32'h1);
    expStat = (32'h1 << POS[10]) | 32'h1;
    wr(A_DIS, 32'h1);
    expMask = 32'h1;
    begin
      logic [5:0] bad [6] = '{6'h08, 6'h0C, 6'h20, 6'h24, 6'h3C, 6'h11};
      for (int i = 0; i < 6; i++) begin
        wr(bad[i], 32'hFFFF_FFFF);
        chk($sformatf("R11 no pulse %h", bad[i]), {21'b0, trigOut}, 32'h0);
        rdChk($sformatf("R11 read zero %h", bad[i]), bad[i], 32'h0);
        rdChk($sformatf("R11 pending kept %h", bad[i]), A_STAT, expStat);
        rdChk($sformatf("R11 mask kept %h", bad[i]), A_MASK, expMask);
      end
    end

    finish();
  end
endmodule